// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank synchronous DRAM. It takes the memory from power-on to a state where normal traffic may begin. After reset it holds the command bus idle for a settling interval. It then closes every bank with one precharge and waits out the row-precharge time. Next it issues a burst of auto-refresh commands spaced by the row-cycle time, and finally writes the mode register. Once the mode-register delay has elapsed, it raises a done flag. The clock-enable and data-mask pins are held high for the whole time.

All wait lengths are worked out at elaboration from a clock-frequency parameter and from timing parameters in microseconds or nanoseconds, always rounded up. The mode-register contents come from an input port, which is sampled in the cycle the command is issued. Controller logic downstream waits for the done flag before it sends any traffic.

Top module: `sdram_init_seq`

## Requirements
- R1: `cke` and `dqm` are high on every cycle, both during and after reset.
- R2: The command pins {`csN`,`rasN`,`casN`,`weN`} carry 0111 (no-operation) on every cycle that is not a command. The command codes are 0010 for precharge, 0001 for auto-refresh and 0000 for mode-register set. Reset drives no-operation.
- R3: The first command after reset is released is a precharge. It appears exactly SETTLE_US*CLK_MHZ cycles after the release.
- R4: The precharge drives address bit 10 high and every other address bit low, with `ba` at zero, so that it closes all banks.
- R5: The first auto-refresh follows the precharge by exactly ceil(TRP_NS*CLK_MHZ/1000) cycles.
- R6: Exactly REFRESHES auto-refresh commands are issued. Each one after the first follows the previous one by exactly ceil(TRC_NS*CLK_MHZ/1000) cycles.
- R7: The mode-register set follows the last auto-refresh by the same row-cycle count. It carries `modeValue` on `addr` and zero on `ba`.
- R8: `initDone` rises exactly TMRD_CYC cycles after the mode-register set.
- R9: Once high, `initDone` stays high until reset, and no further command is issued.
- R10: A synchronous active-high `rst` at any point drops `initDone`, idles the command bus, and restarts the whole sequence from the settling wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| modeValue | input | ADDR_W | Value written to the mode register |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus; bit 10 selects all banks on precharge |
| ba | output | BANK_W | Bank address |
| cke | output | 1 | Clock enable, held high |
| dqm | output | 1 | Data mask, held high |
| initDone | output | 1 | Sticky flag: initialization finished |

## Verification
The assertions assume that `rst` is high at the first clock edge, so that every counter and register starts from a known value. They also assume that ADDR_W is at least 11, so that bit 10 exists. The bench holds reset for several cycles before each release and uses a 12-bit address. It changes `modeValue` only between sequences, never in the mode-register cycle. Its one mid-sequence reset is applied at a negative clock edge, in the middle of the refresh burst, and the bench then confirms that the full sequence restarts.

// File: rtl/sdram_init_pkg.sv
`timescale 1ns/1ps
package sdram_init_pkg;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  typedef enum logic [2:0] {
    ST_SETTLE,
    ST_WAIT_RP,
    ST_WAIT_RC,
    ST_WAIT_MRD,
    ST_DONE
  } seqState_t;

  // Control-to-datapath strobes, at most one active per cycle
  typedef struct packed {
    logic issuePre;
    logic issueRef;
    logic issueMrs;
    logic setDone;
  } seqStrobe_t;

  function automatic int unsigned cyclesFromNs(int unsigned ns, int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned atLeastOne(int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int unsigned maxOf4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sdram_init_ctrl.sv
`timescale 1ns/1ps
module sdram_init_ctrl
  import sdram_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       waitDone,
  input  logic       refDone,
  output seqStrobe_t strobe
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_SETTLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_SETTLE: if (waitDone) begin
        strobe.issuePre = 1'b1;
        stateNext       = ST_WAIT_RP;
      end
      ST_WAIT_RP: if (waitDone) begin
        strobe.issueRef = 1'b1;
        stateNext       = ST_WAIT_RC;
      end
      ST_WAIT_RC: if (waitDone) begin
        if (refDone) begin
          strobe.issueMrs = 1'b1;
          stateNext       = ST_WAIT_MRD;
        end else begin
          strobe.issueRef = 1'b1;
        end
      end
      ST_WAIT_MRD: if (waitDone) begin
        strobe.setDone = 1'b1;
        stateNext      = ST_DONE;
      end
      ST_DONE: stateNext = ST_DONE;
      default: stateNext = ST_SETTLE;
    endcase
  end

  // R2: a single command per cycle
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe));

  // R10: leaving reset always starts from the settling wait
  assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> state == ST_SETTLE);

  // R9: nothing is issued once finished
  assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (rst)
    state == ST_DONE |=> strobe == '0);

endmodule

// File: rtl/sdram_init_dp.sv
`timescale 1ns/1ps
module sdram_init_dp
  import sdram_init_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 20000,
  parameter int unsigned RP_CYC     = 2,
  parameter int unsigned RC_CYC     = 7,
  parameter int unsigned MRD_CYC    = 2,
  parameter int unsigned REFRESHES  = 8,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned BANK_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] modeValue,
  output logic              waitDone,
  output logic              refDone,
  output logic [3:0]        cmdQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic [BANK_W-1:0] baQ,
  output logic              doneQ
);

  localparam int unsigned MAX_CYC = maxOf4(SETTLE_CYC, RP_CYC, RC_CYC, MRD_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam int unsigned REF_W   = $clog2(REFRESHES + 1);
  localparam int unsigned ALL_BANKS_BIT = 10;

  logic [CNT_W-1:0] waitCnt;
  logic [REF_W-1:0] refCnt;

  // Shared down-counter: loaded with (wait - 1) the cycle a command is issued
  always_ff @(posedge clk) begin
    if (rst)                  waitCnt <= CNT_W'(SETTLE_CYC - 1);
    else if (strobe.issuePre) waitCnt <= CNT_W'(RP_CYC - 1);
    else if (strobe.issueRef) waitCnt <= CNT_W'(RC_CYC - 1);
    else if (strobe.issueMrs) waitCnt <= CNT_W'(MRD_CYC - 1);
    else if (waitCnt != '0)   waitCnt <= waitCnt - 1'b1;
  end
  assign waitDone = (waitCnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                                        refCnt <= '0;
    else if (strobe.issueRef && !refDone)           refCnt <= refCnt + 1'b1;
  end
  assign refDone = (refCnt == REF_W'(REFRESHES));

  // Registered command bus
  always_ff @(posedge clk) begin
    if (rst) begin
      cmdQ  <= CMD_NOP;
      addrQ <= '0;
      baQ   <= '0;
    end else begin
      cmdQ  <= CMD_NOP;
      addrQ <= '0;
      baQ   <= '0;
      if (strobe.issuePre) begin
        cmdQ                 <= CMD_PRE;
        addrQ[ALL_BANKS_BIT] <= 1'b1;
      end else if (strobe.issueRef) begin
        cmdQ <= CMD_REF;
      end else if (strobe.issueMrs) begin
        cmdQ  <= CMD_MRS;
        addrQ <= modeValue;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 doneQ <= 1'b0;
    else if (strobe.setDone) doneQ <= 1'b1;
  end

  // R4: precharge closes all banks
  assert_a10_on_precharge_R4: assert property (@(posedge clk) disable iff (rst)
    strobe.issuePre |=> (cmdQ == CMD_PRE) && addrQ[ALL_BANKS_BIT]);

  // R6: no command leaves before its wait is over
  assert_wait_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe.issuePre || strobe.issueRef || strobe.issueMrs || strobe.setDone) |-> waitDone);

  // R7: mode register set only after the full refresh burst
  assert_burst_complete_R7: assert property (@(posedge clk) disable iff (rst)
    strobe.issueMrs |-> refDone);

  // R9: done is sticky
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> doneQ);

  // R9: bus idles once done
  assert_idle_when_done_R9: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> cmdQ == CMD_NOP);

endmodule

// File: rtl/sdram_init_seq.sv
`timescale 1ns/1ps
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned SETTLE_US = 200,
  parameter int unsigned TRP_NS    = 20,
  parameter int unsigned TRC_NS    = 70,
  parameter int unsigned TMRD_CYC  = 2,
  parameter int unsigned REFRESHES = 8,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BANK_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] modeValue,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              cke,
  output logic              dqm,
  output logic              initDone
);

  localparam int unsigned SETTLE_CYC = atLeastOne(SETTLE_US * CLK_MHZ);
  localparam int unsigned RP_CYC     = cyclesFromNs(TRP_NS, CLK_MHZ);
  localparam int unsigned RC_CYC     = cyclesFromNs(TRC_NS, CLK_MHZ);
  localparam int unsigned MRD_CYC    = atLeastOne(TMRD_CYC);

  seqStrobe_t strobe;
  logic       waitDone, refDone;
  logic [3:0] cmdQ;

  sdram_init_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .waitDone (waitDone),
    .refDone  (refDone),
    .strobe   (strobe)
  );

  sdram_init_dp #(
    .SETTLE_CYC (SETTLE_CYC),
    .RP_CYC     (RP_CYC),
    .RC_CYC     (RC_CYC),
    .MRD_CYC    (MRD_CYC),
    .REFRESHES  (REFRESHES),
    .ADDR_W     (ADDR_W),
    .BANK_W     (BANK_W)
  ) i_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .modeValue (modeValue),
    .waitDone  (waitDone),
    .refDone   (refDone),
    .cmdQ      (cmdQ),
    .addrQ     (addr),
    .baQ       (ba),
    .doneQ     (initDone)
  );

  assign {csN, rasN, casN, weN} = cmdQ;
  assign cke = 1'b1;
  assign dqm = 1'b1;

endmodule

// File: tb/test_sdram_init_seq.sv
`timescale 1ns/1ps
module test_sdram_init_seq;

  localparam int MHZ     = 250;
  localparam int SET_US  = 2;
  localparam int RP_NS   = 20;
  localparam int RC_NS   = 66;
  localparam int MRD     = 2;
  localparam int AW      = 12;

  // Expected spacings from the requirements, rounded up
  localparam int EXP_SETTLE = SET_US * MHZ;
  localparam int EXP_RP     = (RP_NS * MHZ + 999) / 1000;
  localparam int EXP_RC     = (RC_NS * MHZ + 999) / 1000;

  // Event codes seen at the pins
  localparam int EV_PRE  = 0;
  localparam int EV_REF  = 1;
  localparam int EV_MRS  = 2;
  localparam int EV_DONE = 3;
  localparam int EV_BAD  = 9;

  localparam int NVEC = 11;
  localparam int VEC_EVT [NVEC] = '{EV_PRE, EV_REF, EV_REF, EV_REF, EV_REF, EV_REF,
                                    EV_REF, EV_REF, EV_REF, EV_MRS, EV_DONE};
  localparam int VEC_GAP [NVEC] = '{EXP_SETTLE, EXP_RP, EXP_RC, EXP_RC, EXP_RC, EXP_RC,
                                    EXP_RC, EXP_RC, EXP_RC, EXP_RC, MRD};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] modeValue = 12'h032;
  logic          csN, rasN, casN, weN, cke, dqm, initDone;
  logic [AW-1:0] addr;
  logic [1:0]    ba;

  int checks = 0;
  int fails  = 0;
  int ckeBad = 0;
  bit prevDone = 1'b0;

  always #2 clk = ~clk;

  sdram_init_seq #(
    .CLK_MHZ(MHZ), .SETTLE_US(SET_US), .TRP_NS(RP_NS), .TRC_NS(RC_NS),
    .TMRD_CYC(MRD), .REFRESHES(8), .ADDR_W(AW), .BANK_W(2)
  ) i_sdram_init_seq (
    .clk(clk), .rst(rst), .modeValue(modeValue),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .ba(ba), .cke(cke), .dqm(dqm), .initDone(initDone)
  );

  // R1 monitor
  always @(negedge clk) if (!(cke === 1'b1 && dqm === 1'b1)) ckeBad++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pins();
    return {csN, rasN, casN, weN};
  endfunction

  // Steps one cycle at a time until a command or the rise of initDone
  task automatic waitEvent(output int evt, output int gap);
    gap = 0;
    evt = -1;
    while (evt < 0) begin
      @(negedge clk);
      gap++;
      case (pins())
        4'b0111: if (initDone && !prevDone) evt = EV_DONE;
        4'b0010: evt = EV_PRE;
        4'b0001: evt = EV_REF;
        4'b0000: evt = EV_MRS;
        default: evt = EV_BAD;
      endcase
      prevDone = initDone;
    end
  endtask

  function automatic string gapTag(input int i);
    if (i == 0)  return "R3";
    if (i == 1)  return "R5";
    if (i <= 8)  return "R6";
    if (i == 9)  return "R7";
    return "R8";
  endfunction

  task automatic walkFrom(input int first);
    int evt, gap;
    for (int i = first; i < NVEC; i++) begin
      waitEvent(evt, gap);
      check(evt == VEC_EVT[i], "R2 order", evt, VEC_EVT[i]);
      check(gap == VEC_GAP[i], gapTag(i), gap, VEC_GAP[i]);
      if (evt == EV_PRE)
        check(addr == 12'h400 && ba == 2'd0, "R4 precharge address", int'(addr), 12'h400);
      if (evt == EV_MRS)
        check(addr == modeValue && ba == 2'd0, "R7 mode value", int'(addr), int'(modeValue));
    end
  endtask

  initial begin
    int evt, gap, quietBad;
    // Reset state
    repeat (4) @(negedge clk);
    check(pins() == 4'b0111, "R2 reset NOP", int'(pins()), 4'b0111);
    check(initDone == 1'b0, "R10 reset done low", int'(initDone), 0);
    check(cke && dqm, "R1 reset cke/dqm", int'({cke, dqm}), 3);
    rst = 1'b0;
    prevDone = 1'b0;

    // Full sequence from the vector table
    walkFrom(0);

    // R9: sticky done and silent bus
    quietBad = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (!initDone || pins() != 4'b0111) quietBad++;
    end
    check(quietBad == 0, "R9 done sticky, bus idle", quietBad, 0);

    // R10: reset in the middle of the refresh burst
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    prevDone = 1'b0;
    waitEvent(evt, gap);
    check(evt == EV_PRE && gap == EXP_SETTLE, "R10 restart precharge", gap, EXP_SETTLE);
    for (int k = 0; k < 3; k++) waitEvent(evt, gap);
    check(evt == EV_REF, "R10 in burst", evt, EV_REF);
    rst = 1'b1;
    @(negedge clk);
    check(pins() == 4'b0111, "R10 reset idles bus", int'(pins()), 4'b0111);
    check(initDone == 1'b0, "R10 done cleared", int'(initDone), 0);
    repeat (2) @(negedge clk);
    modeValue = 12'h2A5;
    rst = 1'b0;
    prevDone = 1'b0;
    walkFrom(0);

    check(ckeBad == 0, "R1 cke/dqm always high", ckeBad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule